// File: doc/BRIEF.md
# Row-to-Column Command Spacing Checker

This block sits beside the two command channels of a packetized DRAM interface, one carrying row commands (open, close, refresh) and one carrying column commands (read, write, retire, no-op). It keeps a record of the latest row command that opened or closed a bank. Each incoming column command is compared against that record. From the device and bank of both commands, the block works out how many cycles the column command had to trail the row command. If the bank it targets is necessarily closed, it marks the access as illegal instead.

Each channel carries a cycle stamp taken from a free-running counter. The block takes the wrapping difference of the two stamps as the actual gap. When a column command comes too early, the spacing flag goes high in the same cycle the command is presented. A row command is recorded at the clock edge that ends its valid cycle. A column command presented in that same cycle is therefore judged against the earlier record. A column command whose stamp lies before the recorded row stamp is treated as a column-before-row pair and is not judged here.

Top module: `rowcol_spacing_chk`

## Requirements
- R1: After reset no row command is recorded; column commands then give `req_delay` 0 and both flags low.
- R2: A column command to a device other than the recorded row command's device gives `req_delay` 0 and both flags low.
- R3: After an open (row_op 1) to device D, a column no-op (col_op 0) to D gives `req_delay` 0 and both flags low.
- R4: After an open of bank B on device D, a read (1), write (2) or retire (3) to D at a bank other than B, B-1, B+1 gives `req_delay` 0 and both flags low.
- R5: After an open of bank B, any read, write or retire to bank B-1 or B+1 of the same device sets `illegal_err`, with `req_delay` 0 and `spacing_err` low.
- R6: After an open of bank B, a read, write or retire to bank B of the same device gives `req_delay` = T_RCD (default 7). `spacing_err` is high exactly when the gap (col_time - row_time modulo 2^TW) is below T_RCD. This holds across stamp wrap-around.
- R7: After a close (row_op 2) of bank B, a read, write or retire to B, B-1 or B+1 of the same device sets `illegal_err`, with `req_delay` 0.
- R8: After a close, a no-op or an access to a non-adjacent bank gives `req_delay` 0 and both flags low.
- R9: A column command whose stamp precedes the recorded row stamp (wrapping difference negative) gives `req_delay` 0 and both flags low.
- R10: A refresh-open (row_op 3) is recorded like an open and a refresh-close (row_op 4) like a close. A row no-op (row_op 0) leaves the record unchanged.
- R11: Bank adjacency does not wrap: bank 0 and bank 2^BANK_W-1 are not neighbours.
- R12: Outputs are combinational in the cycle of the column command; with `col_valid` low, `req_delay` is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_valid | input | 1 | Row command present this cycle |
| row_op | input | 3 | Row opcode: 0 no-op, 1 open, 2 close, 3 refresh-open, 4 refresh-close |
| row_dev | input | DEV_W | Row command device |
| row_bank | input | BANK_W | Row command bank |
| row_time | input | TW | Row channel cycle stamp |
| col_valid | input | 1 | Column command present this cycle |
| col_op | input | 2 | Column opcode: 0 no-op, 1 read, 2 write, 3 retire |
| col_dev | input | DEV_W | Column command device |
| col_bank | input | BANK_W | Column command bank |
| col_time | input | TW | Column channel cycle stamp |
| req_delay | output | DLY_W | Minimum row-to-column gap for this column command |
| spacing_err | output | 1 | Column command arrived before the required gap elapsed |
| illegal_err | output | 1 | Column access targets a bank that must be closed |

## Verification
The column command is varied against a fixed recorded row command: another device, the same bank, each neighbour, a distant bank, and a no-op. Each pattern gives a distinct outcome among zero, T_RCD and illegal, so a wrong device or bank match shows up. Gaps just below, at, and across the stamp wrap point separate a correct spacing compare from an off-by-one or an unsigned difference. Stamps that run backwards, refresh opcodes, row no-ops and the edge banks 0 and 15 check the ordering filter, the opcode mapping, record retention and the non-wrapping adjacency.

// File: rtl/rcc_pkg.sv
// Shared encodings for the row-to-column spacing checker.
// Assumes: opcode values are fixed by the command channels.
package rcc_pkg;
    typedef enum logic [2:0] {
        ROW_NOP  = 3'd0,
        ROW_ACT  = 3'd1,
        ROW_PRE  = 3'd2,
        ROW_REFA = 3'd3,
        ROW_REFP = 3'd4
    } row_op_e;

    typedef enum logic [1:0] {
        COL_NOP    = 2'd0,
        COL_RD     = 2'd1,
        COL_WR     = 2'd2,
        COL_RETIRE = 2'd3
    } col_op_e;

    // What the latest relevant row command did to its bank.
    typedef enum logic [1:0] {
        HELD_NONE  = 2'd0,
        HELD_OPEN  = 2'd1,
        HELD_CLOSE = 2'd2
    } held_kind_e;
endpackage

// File: rtl/row_tracker.sv
// Records the latest row command that opens or closes a bank.
// Refresh-open counts as open, refresh-close as close; row no-ops
// and unknown opcodes leave the record untouched.
// Assumes: one row command per cycle at most.
module row_tracker
    import rcc_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4,
    parameter int TW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic [2:0]        row_op,
    input  logic [DEV_W-1:0]  row_dev,
    input  logic [BANK_W-1:0] row_bank,
    input  logic [TW-1:0]     row_time,
    output held_kind_e        held_kind,
    output logic [DEV_W-1:0]  held_dev,
    output logic [BANK_W-1:0] held_bank,
    output logic [TW-1:0]     held_time
);
    held_kind_e new_kind;

    // Map the row opcode to its effect on the bank.
    always_comb begin
        case (row_op)
            ROW_ACT, ROW_REFA: new_kind = HELD_OPEN;
            ROW_PRE, ROW_REFP: new_kind = HELD_CLOSE;
            default:           new_kind = HELD_NONE;
        endcase
    end

    // Capture the row command when it changes bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_kind <= HELD_NONE;
            held_dev  <= '0;
            held_bank <= '0;
            held_time <= '0;
        end else if (row_valid && new_kind != HELD_NONE) begin
            held_kind <= new_kind;
            held_dev  <= row_dev;
            held_bank <= row_bank;
            held_time <= row_time;
        end
    end

    // R10
    open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && (row_op == ROW_ACT || row_op == ROW_REFA)) |=> held_kind == HELD_OPEN);
    // R10
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_valid || row_op == ROW_NOP) |=> $stable(held_bank) && $stable(held_time));
endmodule

// File: rtl/rc_rule.sv
// Decides the required row-to-column gap from packet contents:
// zero, T_RCD, or illegal. Adjacency uses one extra bit so that
// the lowest and highest banks are never neighbours.
// Assumes: held_kind is HELD_NONE until a row command is recorded.
module rc_rule
    import rcc_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4,
    parameter int DLY_W  = 8,
    parameter int T_RCD  = 7
) (
    input  held_kind_e        held_kind,
    input  logic [DEV_W-1:0]  held_dev,
    input  logic [BANK_W-1:0] held_bank,
    input  logic [1:0]        col_op,
    input  logic [DEV_W-1:0]  col_dev,
    input  logic [BANK_W-1:0] col_bank,
    output logic [DLY_W-1:0]  need_dly,
    output logic              illegal
);
    localparam int EW = BANK_W + 1;
    localparam logic [DLY_W-1:0] RCD = DLY_W'(T_RCD);

    logic          same_dev, access, hit, adj;
    logic [EW-1:0] cb_x, hb_x;

    // Compare column target with the recorded row target.
    always_comb begin
        cb_x     = {1'b0, col_bank};
        hb_x     = {1'b0, held_bank};
        same_dev = (col_dev == held_dev);
        access   = (col_op != COL_NOP);
        hit      = (col_bank == held_bank);
        adj      = (cb_x + 1'b1 == hb_x) || (hb_x + 1'b1 == cb_x);
    end

    // Select the gap class.
    always_comb begin
        need_dly = '0;
        illegal  = 1'b0;
        if (same_dev && access) begin
            case (held_kind)
                HELD_OPEN: begin
                    if (hit)      need_dly = RCD;
                    else if (adj) illegal  = 1'b1;
                end
                HELD_CLOSE: illegal = hit || adj;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gap_eval.sv
// Measures the wrapping gap between row and column stamps, tells
// whether the column stamp is not earlier, and whether the gap is
// shorter than required.
// Assumes: real gaps stay below half the stamp range.
module gap_eval #(
    parameter int TW    = 16,
    parameter int DLY_W = 8
) (
    input  logic [TW-1:0]    row_time,
    input  logic [TW-1:0]    col_time,
    input  logic [DLY_W-1:0] need_dly,
    output logic             ordered,
    output logic             short_gap
);
    localparam int CW = (TW > DLY_W) ? TW : DLY_W;

    logic [TW-1:0] diff;

    // Signed wrapping difference and comparison with the requirement.
    always_comb begin
        diff      = col_time - row_time;
        ordered   = !diff[TW-1];
        short_gap = ordered && (CW'(diff) < CW'(need_dly));
    end
endmodule

// File: rtl/rowcol_spacing_chk.sv
// Top of the row-to-column spacing checker. Combines the row
// record, the gap rule and the stamp comparison into per-column-
// command outputs valid in the same cycle as col_valid.
// Assumes: a row and column command in the same cycle pair the
// column with the previously recorded row command.
module rowcol_spacing_chk
    import rcc_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4,
    parameter int TW     = 16,
    parameter int DLY_W  = 8,
    parameter int T_RCD  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic [2:0]        row_op,
    input  logic [DEV_W-1:0]  row_dev,
    input  logic [BANK_W-1:0] row_bank,
    input  logic [TW-1:0]     row_time,
    input  logic              col_valid,
    input  logic [1:0]        col_op,
    input  logic [DEV_W-1:0]  col_dev,
    input  logic [BANK_W-1:0] col_bank,
    input  logic [TW-1:0]     col_time,
    output logic [DLY_W-1:0]  req_delay,
    output logic              spacing_err,
    output logic              illegal_err
);
    held_kind_e        held_kind;
    logic [DEV_W-1:0]  held_dev;
    logic [BANK_W-1:0] held_bank;
    logic [TW-1:0]     held_time;
    logic [DLY_W-1:0]  need_dly;
    logic              illegal, ordered, short_gap, active;

    row_tracker #(.DEV_W(DEV_W), .BANK_W(BANK_W), .TW(TW)) u_trk (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_op(row_op),
        .row_dev(row_dev), .row_bank(row_bank), .row_time(row_time),
        .held_kind(held_kind), .held_dev(held_dev),
        .held_bank(held_bank), .held_time(held_time)
    );

    rc_rule #(.DEV_W(DEV_W), .BANK_W(BANK_W), .DLY_W(DLY_W), .T_RCD(T_RCD)) u_rule (
        .held_kind(held_kind), .held_dev(held_dev), .held_bank(held_bank),
        .col_op(col_op), .col_dev(col_dev), .col_bank(col_bank),
        .need_dly(need_dly), .illegal(illegal)
    );

    gap_eval #(.TW(TW), .DLY_W(DLY_W)) u_gap (
        .row_time(held_time), .col_time(col_time), .need_dly(need_dly),
        .ordered(ordered), .short_gap(short_gap)
    );

    // Drive outputs only for an ordered column command with a record.
    always_comb begin
        active      = col_valid && (held_kind != HELD_NONE) && ordered;
        req_delay   = (active && !illegal) ? need_dly : '0;
        illegal_err = active && illegal;
        spacing_err = active && !illegal && short_gap;
    end

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spacing_err && illegal_err));
    // R6
    spacing_needs_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |-> req_delay == DLY_W'(T_RCD));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (req_delay == '0 && !spacing_err && !illegal_err));
    // R7
    illegal_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> (col_op != COL_NOP && col_dev == held_dev));
    // R2
    devmatch_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_delay != '0) |-> (col_dev == held_dev && held_kind == HELD_OPEN));
endmodule

// File: tb/rowcol_spacing_chk_test.sv
module rowcol_spacing_chk_test;
    localparam int RCD = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_valid = 1'b0;
    logic [2:0]  row_op = '0;
    logic [4:0]  row_dev = '0;
    logic [3:0]  row_bank = '0;
    logic [15:0] row_time = '0;
    logic        col_valid = 1'b0;
    logic [1:0]  col_op = '0;
    logic [4:0]  col_dev = '0;
    logic [3:0]  col_bank = '0;
    logic [15:0] col_time = '0;
    logic [7:0]  req_delay;
    logic        spacing_err, illegal_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rowcol_spacing_chk uut (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_op(row_op),
        .row_dev(row_dev), .row_bank(row_bank), .row_time(row_time),
        .col_valid(col_valid), .col_op(col_op), .col_dev(col_dev),
        .col_bank(col_bank), .col_time(col_time),
        .req_delay(req_delay), .spacing_err(spacing_err), .illegal_err(illegal_err)
    );

    always #4 clk = ~clk;

    task automatic row_cmd(input logic [2:0] op, input logic [4:0] dev,
                           input logic [3:0] bank, input logic [15:0] t);
        @(negedge clk);
        row_valid = 1'b1; row_op = op; row_dev = dev; row_bank = bank; row_time = t;
        @(negedge clk);
        row_valid = 1'b0;
    endtask

    task automatic col_probe(input logic v, input logic [1:0] op, input logic [4:0] dev,
                             input logic [3:0] bank, input logic [15:0] t,
                             input logic [7:0] e_dly, input logic e_sp, input logic e_il,
                             input string tag);
        @(negedge clk);
        col_valid = v; col_op = op; col_dev = dev; col_bank = bank; col_time = t;
        #1;
        checks++;
        if (req_delay !== e_dly || spacing_err !== e_sp || illegal_err !== e_il) begin
            errors++;
            $display("FAIL %s: got dly=%0d sp=%0b il=%0b, expected dly=%0d sp=%0b il=%0b",
                     tag, req_delay, spacing_err, illegal_err, e_dly, e_sp, e_il);
        end
        #1 col_valid = 1'b0;
    endtask

    // R1 reset state, R12 idle outputs
    task automatic t_reset();
        col_probe(1, 1, 5'd1, 4'd5, 16'd10, 0, 0, 0, "R1 no record");
        col_probe(0, 1, 5'd1, 4'd5, 16'd10, 0, 0, 0, "R12 idle");
    endtask

    // R2..R6 after an open of bank 5 on device 1
    task automatic t_open();
        row_cmd(3'd1, 5'd1, 4'd5, 16'd100);
        col_probe(1, 1, 5'd2, 4'd5, 16'd101, 0, 0, 0, "R2 other device");
        col_probe(1, 0, 5'd1, 4'd5, 16'd101, 0, 0, 0, "R3 col no-op");
        col_probe(1, 1, 5'd1, 4'd9, 16'd101, 0, 0, 0, "R4 far bank read");
        col_probe(1, 3, 5'd1, 4'd2, 16'd101, 0, 0, 0, "R4 far bank retire");
        col_probe(1, 2, 5'd1, 4'd4, 16'd101, 0, 0, 1, "R5 lower neighbour");
        col_probe(1, 1, 5'd1, 4'd6, 16'd101, 0, 0, 1, "R5 upper neighbour");
        col_probe(1, 1, 5'd1, 4'd5, 16'd103, RCD, 1, 0, "R6 gap 3");
        col_probe(1, 2, 5'd1, 4'd5, 16'd106, RCD, 1, 0, "R6 gap 6");
        col_probe(1, 1, 5'd1, 4'd5, 16'd107, RCD, 0, 0, "R6 gap 7");
        col_probe(1, 1, 5'd1, 4'd5, 16'd100, RCD, 1, 0, "R6 gap 0");
        col_probe(0, 1, 5'd1, 4'd5, 16'd103, 0, 0, 0, "R12 idle after open");
    endtask

    // R6 stamp wrap
    task automatic t_wrap();
        row_cmd(3'd1, 5'd3, 4'd7, 16'd65533);
        col_probe(1, 1, 5'd3, 4'd7, 16'd2, RCD, 1, 0, "R6 wrap gap 5");
        col_probe(1, 1, 5'd3, 4'd7, 16'd4, RCD, 0, 0, "R6 wrap gap 7");
    endtask

    // R7, R8 after a close of bank 5
    task automatic t_close();
        row_cmd(3'd2, 5'd1, 4'd5, 16'd200);
        col_probe(1, 1, 5'd1, 4'd5, 16'd201, 0, 0, 1, "R7 same bank");
        col_probe(1, 2, 5'd1, 4'd4, 16'd201, 0, 0, 1, "R7 lower neighbour");
        col_probe(1, 3, 5'd1, 4'd6, 16'd201, 0, 0, 1, "R7 upper neighbour");
        col_probe(1, 1, 5'd1, 4'd8, 16'd201, 0, 0, 0, "R8 far bank");
        col_probe(1, 0, 5'd1, 4'd5, 16'd201, 0, 0, 0, "R8 col no-op");
    endtask

    // R9 column stamp earlier than row stamp
    task automatic t_order();
        row_cmd(3'd1, 5'd1, 4'd5, 16'd300);
        col_probe(1, 1, 5'd1, 4'd5, 16'd298, 0, 0, 0, "R9 earlier same bank");
        col_probe(1, 1, 5'd1, 4'd6, 16'd299, 0, 0, 0, "R9 earlier neighbour");
    endtask

    // R10 refresh opcodes and row no-op
    task automatic t_refresh();
        row_cmd(3'd3, 5'd1, 4'd3, 16'd400);
        col_probe(1, 1, 5'd1, 4'd3, 16'd402, RCD, 1, 0, "R10 refresh-open");
        row_cmd(3'd0, 5'd1, 4'd9, 16'd403);
        col_probe(1, 1, 5'd1, 4'd3, 16'd403, RCD, 1, 0, "R10 row no-op keeps record");
        row_cmd(3'd4, 5'd1, 4'd3, 16'd500);
        col_probe(1, 1, 5'd1, 4'd4, 16'd501, 0, 0, 1, "R10 refresh-close");
    endtask

    // R11 edge banks are not neighbours
    task automatic t_edges();
        row_cmd(3'd1, 5'd1, 4'd0, 16'd600);
        col_probe(1, 1, 5'd1, 4'd15, 16'd601, 0, 0, 0, "R11 bank15 vs open 0");
        col_probe(1, 1, 5'd1, 4'd1, 16'd601, 0, 0, 1, "R11 bank1 vs open 0");
        row_cmd(3'd2, 5'd1, 4'd15, 16'd700);
        col_probe(1, 1, 5'd1, 4'd0, 16'd701, 0, 0, 0, "R11 bank0 vs close 15");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_open();
        t_wrap();
        t_close();
        t_order();
        t_refresh();
        t_edges();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule